// File: doc/BRIEF.md
# Complementary Fast PWM Timer with Byte-Wide Register Access

This block is a 10-bit up-counting PWM generator for a switching audio output stage. A free-running counter climbs from zero to a programmable ceiling and then restarts. The main output stays high while the count is below a duty value, and a second pin always carries the inverse of it. Driven at the midpoint duty, the stage idles at about 50 %, which is the quiet state with no signal. A sample source moves the duty value up and down from there to carry the audio.

Software reaches the 10-bit ceiling and duty values over an 8-bit bus. The two top bits of every wide value go through one shared high-byte holding register. To write a wide value, software loads the holding register first and then the low byte, and the whole 10-bit value changes on that low-byte write. To read one, software reads the low byte first; that access copies the top bits into the holding register, and software then reads them from it. The counter clock is either the input clock or the input clock divided by two. A new duty value is held in a buffer and reaches the comparator only when the count wraps.

Top module: `cpwm_timer`

## Requirements
- R1: The counter advances by one on each count tick. When it is at or above the ceiling it returns to 0, so one period lasts ceiling+1 ticks.
- R2: When `div2_sel` is 0 every clock is a count tick. When it is 1 every second clock is a count tick, so one period lasts 2×(ceiling+1) clocks.
- R3: A write to a low-byte address loads all 10 bits in that cycle: bits 7:0 come from `wdata` and bits 9:8 come from the holding register as it stood before the write. A write to the holding register alone leaves both wide values unchanged.
- R4: A read of a low-byte address returns bits 7:0 on `rdata`. In the same access it copies that value's bits 9:8 into the holding register. A read of the holding register returns its two bits in `rdata[1:0]`, with zeros above.
- R5: `pwm_out` is high for each tick whose count is below the active duty value. Each period therefore has min(duty, ceiling+1) high ticks: a duty of 0 gives a constant low, and a duty above the ceiling gives a constant high.
- R6: A duty value that is written is buffered. It becomes active only at a counter wrap, so a period that is already running keeps its old duty.
- R7: `pwm_out_n` is always the inverse of `pwm_out`.
- R8: After reset the counter, the duty value and the holding register are 0, the ceiling is 1023, `pwm_out` is 0 and `pwm_out_n` is 1.
- R9: Address map on `addr`: 0 is the holding register, 1 is the duty low byte, 2 is the ceiling low byte and 3 is the counter low byte (read only). `rdata` is valid in the same cycle while `rd_en` is high and reads 0 otherwise. If `wr_en` and `rd_en` are both high, only the write acts.
- R10: With ceiling 1023, duty 511 and no division, 511 of every 1024 clocks are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div2_sel | input | 1 | 1 makes the counter tick every second clock |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe for one clock |
| rd_en | input | 1 | Read strobe for one clock |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| pwm_out | output | 1 | Main PWM output |
| pwm_out_n | output | 1 | Inverse PWM output |

## Verification
A corrupted holding register shows up at once: the next wide write stores wrong top bits, and the next readback of the holding register after a low-byte read returns wrong bits. A counter that misses its wrap, or a prescale phase that slips, changes the measured period within one PWM period. A duty value that leaks past the buffer in mid-period gives a stray high pulse in that same period. The bench therefore checks periods, high-tick counts over whole periods, and the low stretch that must follow a duty write made in mid-period.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CPWM_CNT_W = 10;
  localparam int CPWM_BUS_W = 8;

  typedef enum logic [1:0] {
    REG_HIBUF  = 2'd0,
    REG_DUTY   = 2'd1,
    REG_PERIOD = 2'd2,
    REG_COUNT  = 2'd3
  } cpwm_reg_e;
endpackage

// File: rtl/cpwm_rst_sync.sv
module cpwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cpwm_prescale.sv
module cpwm_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic div2_sel,
  output logic tick
);
  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = div2_sel ? ~phase_q : 1'b0;
    tick    = ~div2_sel | phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  // R2: in divide-by-2 mode a tick is never followed by another tick
  p_div2_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div2_sel && tick) |=> (!div2_sel || !tick));
  // R2: undivided mode ticks every clock
  p_div1_every_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !div2_sel |-> tick);
endmodule

// File: rtl/cpwm_regfile.sv
module cpwm_regfile
  import cpwm_pkg::*;
#(
  parameter int CNT_W = CPWM_CNT_W,
  parameter int BUS_W = CPWM_BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [BUS_W-1:0] rdata,
  output logic [CNT_W-1:0] duty_buf,
  output logic [CNT_W-1:0] period
);
  localparam int HI_W = CNT_W - BUS_W;

  cpwm_reg_e  sel;
  logic [HI_W-1:0]  hibuf_q, hibuf_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic [CNT_W-1:0] period_q, period_d;

  assign sel = cpwm_reg_e'(addr);

  // next-state: wide values load on their low-byte write, top bits from hibuf
  always_comb begin
    hibuf_d  = hibuf_q;
    duty_d   = duty_q;
    period_d = period_q;
    if (wr_en) begin
      case (sel)
        REG_HIBUF:  hibuf_d  = wdata[HI_W-1:0];
        REG_DUTY:   duty_d   = {hibuf_q, wdata};
        REG_PERIOD: period_d = {hibuf_q, wdata};
        default:    ;
      endcase
    end else if (rd_en) begin
      case (sel)
        REG_DUTY:   hibuf_d = duty_q[CNT_W-1:BUS_W];
        REG_PERIOD: hibuf_d = period_q[CNT_W-1:BUS_W];
        REG_COUNT:  hibuf_d = cnt_val[CNT_W-1:BUS_W];
        default:    ;
      endcase
    end
  end

  // read multiplexer: low bytes, holding register zero-extended
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        REG_HIBUF:  rdata[HI_W-1:0] = hibuf_q;
        REG_DUTY:   rdata = duty_q[BUS_W-1:0];
        REG_PERIOD: rdata = period_q[BUS_W-1:0];
        REG_COUNT:  rdata = cnt_val[BUS_W-1:0];
        default:    rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hibuf_q  <= '0;
      duty_q   <= '0;
      period_q <= '1;
    end else begin
      hibuf_q  <= hibuf_d;
      duty_q   <= duty_d;
      period_q <= period_d;
    end
  end

  assign duty_buf = duty_q;
  assign period   = period_q;

  // R3: low-byte write merges the earlier holding bits with the bus byte
  p_duty_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> duty_q == {$past(hibuf_q), $past(wdata)});
  p_period_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> period_q == {$past(hibuf_q), $past(wdata)});
  // R3: a holding-register write alone touches neither wide value
  p_hibuf_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> ($stable(duty_q) && $stable(period_q)));
  // R4: low-byte read of duty copies its top bits into the holding register
  p_duty_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 2'd1) |=> hibuf_q == $past(duty_q[CNT_W-1:BUS_W]));
  // R9: nothing on the read bus without a read strobe
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
#(
  parameter int CNT_W = CPWM_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty_buf,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] duty_act
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             at_top;

  // next-state: wrap at or above the ceiling, adopt buffered duty on wrap
  always_comb begin
    at_top = (cnt_q >= period);
    cnt_d  = cnt_q;
    act_d  = act_q;
    if (tick) begin
      if (at_top) begin
        cnt_d = '0;
        act_d = duty_buf;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign cnt      = cnt_q;
  assign duty_act = act_q;

  // R1: increment below the ceiling, wrap to zero at it
  p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q < period) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q >= period) |=> cnt_q == '0);
  // R2: no tick, no movement
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R6: active duty changes only on a wrap
  p_duty_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt_q >= period) |=> $stable(act_q));
endmodule

// File: rtl/cpwm_outstage.sv
module cpwm_outstage
  import cpwm_pkg::*;
#(
  parameter int CNT_W = CPWM_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_act,
  output logic             pwm_out,
  output logic             pwm_out_n
);
  logic hi_d;
  logic pos_q, neg_q;

  always_comb begin
    hi_d = (cnt < duty_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
      neg_q <= 1'b1;
    end else begin
      pos_q <= hi_d;
      neg_q <= ~hi_d;
    end
  end

  assign pwm_out   = pos_q;
  assign pwm_out_n = neg_q;

  // R5: output follows the comparison one clock later
  p_high_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < duty_act) |=> pwm_out);
  p_low_at_or_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= duty_act) |=> !pwm_out);
  // R7: the two separately registered pins never agree
  p_complementary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out != pwm_out_n);
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int CNT_W = CPWM_CNT_W,
  parameter int BUS_W = CPWM_BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div2_sel,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             pwm_out,
  output logic             pwm_out_n
);
  logic             rst_core_n;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_buf;
  logic [CNT_W-1:0] duty_act;
  logic [CNT_W-1:0] period;

  cpwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  cpwm_prescale u_pre (
    .clk(clk), .rst_n(rst_core_n), .div2_sel(div2_sel), .tick(tick)
  );

  cpwm_regfile #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .cnt_val(cnt), .rdata(rdata),
    .duty_buf(duty_buf), .period(period)
  );

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .period(period),
    .duty_buf(duty_buf), .cnt(cnt), .duty_act(duty_act)
  );

  cpwm_outstage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_core_n), .cnt(cnt), .duty_act(duty_act),
    .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
  );

  // R8: ceiling comes out of reset at its maximum
  p_reset_top_r8: assert property (@(posedge clk)
    (!rst_core_n) |=> (!rst_core_n || period == '1));
endmodule

// File: tb/cpwm_timer_test.sv
module cpwm_timer_test;
  logic       clk;
  logic       rst_n;
  logic       div2_sel;
  logic [1:0] addr;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       pwm_out;
  logic       pwm_out_n;

  int checks = 0;
  int errors = 0;
  int compl_bad = 0;
  bit monitor_on = 0;
  bit done = 0;

  string tag_q[$];
  int    exp_q[$];
  int    act_q[$];

  cpwm_timer uut (
    .clk(clk), .rst_n(rst_n), .div2_sel(div2_sel), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // scoreboard monitor: pairs expected items with observed results
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        string t;
        int e, a;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        a = act_q.pop_front();
        checks++;
        if (a != e) begin
          errors++;
          $display("FAIL %s: actual %0d expected %0d", t, a, e);
        end
      end
    end
  end

  // continuous check of the complementary pair
  always @(negedge clk) begin
    if (monitor_on && pwm_out == pwm_out_n) compl_bad++;
  end

  task automatic expect_item(input string t, input int e);
    tag_q.push_back(t);
    exp_q.push_back(e);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #5 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_wide(input logic [1:0] a, input int v);
    bus_wr(2'd0, 8'((v >> 8) & 3));
    bus_wr(a, 8'(v & 255));
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n);
    int h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
    act_q.push_back(h);
  endtask

  task automatic measure_period();
    int p = 0;
    logic prev;
    prev = pwm_out;
    forever begin
      @(negedge clk);
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
    prev = pwm_out;
    forever begin
      @(negedge clk);
      p++;
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
    act_q.push_back(p);
  endtask

  task automatic read_push(input logic [1:0] a);
    logic [7:0] d;
    bus_rd(a, d);
    act_q.push_back(int'(d));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 0; div2_sel = 0; addr = 0; wr_en = 0; rd_en = 0; wdata = 0;
    wait_clks(4);
    rst_n = 1;
    wait_clks(4);
    monitor_on = 1;

    // R8: reset state at the ports
    expect_item("R8 pwm_out after reset", 0);
    act_q.push_back(int'(pwm_out));
    expect_item("R8 pwm_out_n after reset", 1);
    act_q.push_back(int'(pwm_out_n));
    expect_item("R8 holding register after reset", 0);
    read_push(2'd0);
    expect_item("R8 duty low after reset", 0);
    read_push(2'd1);
    expect_item("R8 R4 holding after duty read", 0);
    read_push(2'd0);
    expect_item("R8 R9 ceiling low after reset", 255);
    read_push(2'd2);
    expect_item("R8 R4 ceiling top bits copied", 3);
    read_push(2'd0);

    // R3 R4: write order and read copy
    bus_wr(2'd0, 8'd2);
    bus_wr(2'd1, 8'h34);
    bus_wr(2'd0, 8'd0);
    expect_item("R4 holding overwritten", 0);
    read_push(2'd0);
    expect_item("R3 duty low readback", 8'h34);
    read_push(2'd1);
    expect_item("R3 R4 duty top bits from earlier holding", 2);
    read_push(2'd0);
    bus_wr(2'd0, 8'd1);
    expect_item("R3 holding write leaves duty low", 8'h34);
    read_push(2'd1);
    expect_item("R3 holding write leaves duty top", 2);
    read_push(2'd0);

    // R1 R5 R9: small ceiling
    set_wide(2'd2, 9);
    set_wide(2'd1, 4);
    wait_clks(40);
    bus_rd(2'd3, d);
    expect_item("R9 counter low within ceiling", 1);
    act_q.push_back(int'(d <= 8'd9));
    expect_item("R9 R4 counter top bits", 0);
    read_push(2'd0);
    expect_item("R1 period with ceiling 9", 10);
    measure_period();
    expect_item("R5 duty 4 high ticks", 8);
    count_high(20);

    set_wide(2'd1, 0);
    wait_clks(30);
    expect_item("R5 duty 0 never high", 0);
    count_high(20);

    set_wide(2'd1, 10);
    wait_clks(30);
    expect_item("R5 duty above ceiling always high", 20);
    count_high(20);

    set_wide(2'd1, 1023);
    wait_clks(30);
    expect_item("R5 duty 1023 always high", 20);
    count_high(20);

    // R6: a mid-period write does not reach the running period
    set_wide(2'd1, 3);
    wait_clks(30);
    bus_wr(2'd0, 8'd0);
    begin
      logic prev;
      prev = pwm_out;
      forever begin
        @(negedge clk);
        if (prev && !pwm_out) break;
        prev = pwm_out;
      end
    end
    bus_wr(2'd1, 8'd8);
    expect_item("R6 no pulse before wrap", 0);
    count_high(3);
    wait_clks(30);
    expect_item("R6 new duty after wrap", 16);
    count_high(20);

    // R2: divide by two
    div2_sel = 1;
    set_wide(2'd1, 4);
    wait_clks(80);
    expect_item("R2 high clocks divided", 16);
    count_high(40);
    expect_item("R2 period divided", 20);
    measure_period();

    // R10: idle midpoint at full ceiling
    div2_sel = 0;
    set_wide(2'd2, 1023);
    set_wide(2'd1, 511);
    wait_clks(2 * 1024 + 10);
    expect_item("R10 midpoint duty", 511);
    count_high(1024);

    // R7
    expect_item("R7 complementary mismatches", 0);
    act_q.push_back(compl_bad);

    wait_clks(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule